// File: doc/BRIEF.md
# Four-Function ALU with Condition Flags

A purely combinational arithmetic logic unit of configurable word width (32 bits by default). It has two operand words and a 2-bit function selector. It returns one result word and three condition flags: signed overflow, zero and carry/borrow. The block has no clock and no stored state, so its outputs follow the operands and the selector continuously.

The arithmetic path is a chain of one-bit full-adder slices. The carry of each slice feeds the next slice, so the carry ripples from bit 0 up to the top bit. Each slice is built from two half adders and an OR gate. Subtraction reuses the same chain: an invert control takes the one's complement of the second operand, and the same control forces the carry into bit 0 to one. This gives a + ~b + 1. The result word is picked by a prioritized selection: the logic functions are tested first, and the adder output is the fall-through default.

The unit is meant to sit in the execute stage of a simple processor. A flag register outside the block captures the flags when the surrounding pipeline decides.

Top module: `alu_cc_core`

## Requirements
- R1: With function code 0 (add), the result is opa + opb modulo 2^WIDTH.
- R2: With function code 1 (subtract), the result is opa - opb modulo 2^WIDTH.
- R3: With function code 2, the result is the bitwise AND of opa and opb.
- R4: With function code 3, the result is the bitwise XOR of opa and opb.
- R5: flag_zero is 1 exactly when every bit of the result is 0. This holds for all four function codes.
- R6: For codes 0 and 1, flag_ovf is 1 exactly when the two's-complement result has the wrong sign. For add, this means both operands have the same sign and the result sign differs from it. For subtract, it means the operand signs differ and the result sign differs from the sign of opa.
- R7: For codes 2 and 3, flag_ovf is 0.
- R8: For code 0, flag_carry is the unsigned carry out of the top bit. It is 1 exactly when opa + opb is at least 2^WIDTH.
- R9: For code 1, flag_carry reports an unsigned borrow. It is 1 exactly when opa < opb as unsigned numbers, which is the inverse of the adder's top carry.
- R10: For codes 2 and 3, flag_carry is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn | input | 2 | Function select: 0 add, 1 subtract, 2 AND, 3 XOR |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand (subtrahend for code 1) |
| result | output | WIDTH | Result word |
| flag_ovf | output | 1 | Signed overflow |
| flag_zero | output | 1 | Result is all zeros |
| flag_carry | output | 1 | Carry out for add, borrow for subtract, 0 otherwise |

## Verification
The bench builds two copies side by side: one at the default WIDTH of 32 and one at WIDTH of 8. Both receive the same stimulus, and the narrow copy sees the low byte of each operand. At 32 bits, the directed corner operands exercise the full carry ripple across the word and the sign boundaries at the most-negative and most-positive values. At 8 bits, random operands hit carry, borrow, signed overflow and a zero result many times over. This gives dense flag coverage that random 32-bit words would rarely reach.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  // One half adder: returns {carry, sum}
  function automatic logic [1:0] half_add(input logic x, input logic y);
    return {x & y, x ^ y};
  endfunction

  // Function code selects the inverted-operand / forced-carry path
  function automatic logic fn_is_sub(input logic [1:0] code);
    return code == FN_SUB;
  endfunction

  function automatic logic fn_is_arith(input logic [1:0] code);
    return (code == FN_ADD) || (code == FN_SUB);
  endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_cc_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  logic c_in,
  output logic s_bit,
  output logic c_out
);

  logic [1:0] stage1;
  logic [1:0] stage2;

  always_comb begin
    stage1 = half_add(a_bit, b_bit);
    stage2 = half_add(stage1[0], c_in);
    s_bit  = stage2[0];
    c_out  = stage1[1] | stage2[1];
  end

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_word,
  input  logic [WIDTH-1:0] b_word,
  input  logic             invert_b,
  output logic [WIDTH-1:0] sum_word,
  output logic             carry_top,
  output logic             carry_into_top
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   chain;

  assign b_eff    = invert_b ? ~b_word : b_word;
  assign chain[0] = invert_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a_bit (a_word[i]),
      .b_bit (b_eff[i]),
      .c_in  (chain[i]),
      .s_bit (sum_word[i]),
      .c_out (chain[i+1])
    );
  end

  assign carry_top      = chain[WIDTH];
  assign carry_into_top = chain[MSB];

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int WIDTH = 32
) (
  input  logic             is_arith,
  input  logic             is_sub,
  input  logic [WIDTH-1:0] res_word,
  input  logic             carry_top,
  input  logic             carry_into_top,
  output logic             ovf,
  output logic             zero,
  output logic             carry
);

  always_comb begin
    zero  = ~|res_word;
    ovf   = is_arith & (carry_top ^ carry_into_top);
    carry = is_arith & (carry_top ^ is_sub);
  end

endmodule

// File: rtl/alu_cc_core.sv
module alu_cc_core
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       fn,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] result,
  output logic             flag_ovf,
  output logic             flag_zero,
  output logic             flag_carry
);

  logic             sel_sub;
  logic             sel_arith;
  logic [WIDTH-1:0] adder_sum;
  logic             adder_carry_top;
  logic             adder_carry_into_top;

  assign sel_sub   = fn_is_sub(fn);
  assign sel_arith = fn_is_arith(fn);

  alu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .a_word         (opa),
    .b_word         (opb),
    .invert_b       (sel_sub),
    .sum_word       (adder_sum),
    .carry_top      (adder_carry_top),
    .carry_into_top (adder_carry_into_top)
  );

  // Prioritized pick: logic codes first, adder output is the default
  always_comb begin
    if (fn == FN_AND)      result = opa & opb;
    else if (fn == FN_XOR) result = opa ^ opb;
    else                   result = adder_sum;
  end

  alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .is_arith       (sel_arith),
    .is_sub         (sel_sub),
    .res_word       (result),
    .carry_top      (adder_carry_top),
    .carry_into_top (adder_carry_into_top),
    .ovf            (flag_ovf),
    .zero           (flag_zero),
    .carry          (flag_carry)
  );

endmodule

// File: rtl/alu_cc_checker.sv
module alu_cc_checker #(
  parameter int WIDTH = 32
) (
  input logic [1:0]       fn,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [WIDTH-1:0] result,
  input logic             flag_ovf,
  input logic             flag_zero,
  input logic             flag_carry
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    // R1: adding zero leaves the operand unchanged
    if (fn == 2'd0 && opb == '0)
      a_r1_add_identity: assert (result == opa && !flag_carry && !flag_ovf);
    // R2: equal operands subtract to zero with no borrow
    if (fn == 2'd1 && opa == opb)
      a_r2_sub_self: assert (result == '0 && flag_zero && !flag_carry);
    // R5: zero flag tracks an all-zero result
    a_r5_zero_flag: assert (flag_zero == (result == '0));
    // R6: same-sign add that keeps its sign cannot overflow
    if (fn == 2'd0 && opa[MSB] == opb[MSB] && result[MSB] == opa[MSB])
      a_r6_no_overflow: assert (!flag_ovf);
    // R7 and R10: logic codes clear overflow and carry
    if (fn[1])
      a_r7_logic_flags_clear: assert (!flag_ovf && !flag_carry);
    // R8: unsigned wrap on add shows as a result below opa
    if (fn == 2'd0)
      a_r8_add_carry: assert (flag_carry == (result < opa));
    // R9: borrow on subtract equals unsigned opa < opb
    if (fn == 2'd1)
      a_r9_sub_borrow: assert (flag_carry == (opa < opb));
  end

endmodule

bind alu_cc_core alu_cc_checker #(.WIDTH(WIDTH)) u_alu_cc_checker (
  .fn         (fn),
  .opa        (opa),
  .opb        (opb),
  .result     (result),
  .flag_ovf   (flag_ovf),
  .flag_zero  (flag_zero),
  .flag_carry (flag_carry)
);

// File: tb/alu_cc_core_bench.sv
`timescale 1ns/1ps
module alu_cc_core_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  fn_w;
  logic [31:0] a_w, b_w;
  logic [31:0] r32;
  logic        o32, z32, c32;
  logic [7:0]  r8;
  logic        o8, z8, c8;

  alu_cc_core #(.WIDTH(32)) u_alu_cc_core (
    .fn(fn_w), .opa(a_w), .opb(b_w),
    .result(r32), .flag_ovf(o32), .flag_zero(z32), .flag_carry(c32)
  );

  alu_cc_core #(.WIDTH(8)) u_alu_cc_core_w8 (
    .fn(fn_w), .opa(a_w[7:0]), .opb(b_w[7:0]),
    .result(r8), .flag_ovf(o8), .flag_zero(z8), .flag_carry(c8)
  );

  typedef struct {
    logic [1:0]  fn;
    logic [31:0] a, b;
    logic [34:0] e32;  // {ovf, zero, carry, result}
    logic [34:0] e8;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference: wide integer arithmetic with explicit sign comparison
  function automatic logic [34:0] model(int w, logic [1:0] f, logic [31:0] a, logic [31:0] b);
    longint unsigned mask, au, bu, full, r;
    logic c, o, sa, sb, sr;
    mask = (64'd1 << w) - 64'd1;
    au = {32'd0, a} & mask;
    bu = {32'd0, b} & mask;
    c = 0; o = 0;
    sa = au[w-1]; sb = bu[w-1];
    case (f)
      2'd0: begin full = au + bu; r = full & mask; c = full[w]; end
      2'd1: begin r = (au - bu) & mask; c = au < bu; end
      2'd2: r = au & bu;
      default: r = au ^ bu;
    endcase
    sr = r[w-1];
    if (f == 2'd0) o = (sa == sb) && (sr != sa);
    if (f == 2'd1) o = (sa != sb) && (sr != sa);
    return {o, (r == 0), c, r[31:0]};
  endfunction

  task automatic drive(input logic [1:0] f, input logic [31:0] a, input logic [31:0] b);
    item_t it;
    @(negedge clk);
    fn_w = f; a_w = a; b_w = b;
    it.fn = f; it.a = a; it.b = b;
    it.e32 = model(32, f, a, b);
    it.e8  = model(8, f, a, b);
    q.push_back(it);
  endtask

  function automatic string res_req(logic [1:0] f);
    case (f)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic cmp(string req, string what, int w, logic [31:0] act, logic [31:0] exp, item_t it);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s w%0d fn=%0d a=%h b=%h actual=%h expected=%h",
               req, what, w, it.fn, it.a, it.b, act, exp);
    end
  endtask

  task automatic check_one(int w, logic [31:0] r, logic o, logic z, logic c, logic [34:0] e, item_t it);
    cmp(res_req(it.fn), "result", w, r, e[31:0], it);
    cmp("R5", "zero", w, {31'd0, z}, {31'd0, e[33]}, it);
    cmp(it.fn[1] ? "R7" : "R6", "ovf", w, {31'd0, o}, {31'd0, e[34]}, it);
    cmp(it.fn[1] ? "R10" : (it.fn[0] ? "R9" : "R8"), "carry", w, {31'd0, c}, {31'd0, e[32]}, it);
  endtask

  // Monitor: outputs settle during the half period after the negedge drive
  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check_one(32, r32, o32, z32, c32, it.e32, it);
      check_one(8, {24'd0, r8}, o8, z8, c8, {it.e8[34:32], 24'd0, it.e8[7:0]}, it);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  logic [31:0] corners [8];

  initial begin
    fn_w = 2'd0; a_w = '0; b_w = '0;
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_0000; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h0000_0001; corners[5] = 32'h0000_0080;
    corners[6] = 32'h0000_007F; corners[7] = 32'hA5C3_F00F;
    // Idle state with all-zero inputs: R5 zero flag, R1 sum
    drive(2'd0, 32'd0, 32'd0);
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          drive(f[1:0], corners[i], corners[j]);
    // Equal operands for each code: R2 zero difference, R4 zero xor
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < 20; k++) begin
        logic [31:0] v;
        v = $urandom;
        drive(f[1:0], v, v);
      end
    for (int k = 0; k < 6000; k++)
      drive(2'($urandom), $urandom, $urandom);
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule